// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the wall-clock date and time as seven packed BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Every digit pair keeps its tens digit in bits 7:4 and its units digit in bits 3:0. A one-second strobe advances the seconds, and a carry ripples upward whenever a field passes its top value. Months have their correct lengths, and February follows the leap-year rule for the year window that the block assumes.

A host loads any field through a simple write port and reads any field back through a combinational select. While the host is loading a new time, it raises the hold input so that strobes cannot change a field halfway through the load. The two-digit year is taken to lie in a hundred-year window. The boundary of that window is set by the `YEAR_PIVOT` parameter: values at or above the pivot fall in the 1900s and values below it fall in the 2000s. With the default of 50, the window runs from 1950 to 2049.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset, the fields hold seconds 00, minutes 00, hours 00, weekday 07, day 01, month 01 and year 00. The read select codes are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Code 7 reads 00.
- R2: A strobe with hold low and no write in the same cycle raises the seconds by one in BCD, so 09 becomes 10. Seconds 59 become 00 and carry into the minutes.
- R3: Minutes step from 59 to 00 with a carry into the hours. Hours count in 24-hour form and step from 23 to 00 with a carry into the day.
- R4: The weekday counts from 01 to 07, with 01 meaning Sunday. It steps once on every day carry, and 07 is followed by 01.
- R5: On a day carry, the day of month returns to 01 after its last day and carries into the month. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R6: February (month 02) ends on day 29 when the windowed year is divisible by four, and on day 28 otherwise. With the default pivot, year 00 means 2000 and is a leap year.
- R7: Month 12 returns to 01 and carries into the year. Year 99 returns to 00, and no further carry follows.
- R8: While hold is high, a strobe changes no field.
- R9: When write enable is high, the byte on the write data port goes into the field named by the write select. The value can be read back after the next clock edge. Write select 7 changes no field.
- R10: If a write and a strobe arrive in the same cycle, the write is applied and the strobe is dropped, so no field advances.
- R11: A field that is at or above its top value when it is advanced returns to its bottom value and passes a carry upward. For example, day 31 in April becomes 01 May.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| hold | input | 1 | Freezes every field against strobes |
| wr_en | input | 1 | Host write enable |
| wr_sel | input | 3 | Field written (0 seconds to 6 year) |
| wr_data | input | 8 | Packed BCD value to write |
| rd_sel | input | 3 | Field read (0 seconds to 6 year, 7 reads zero) |
| rd_data | output | 8 | Packed BCD value of the selected field |

## Verification
The bench builds the block with its default `YEAR_PIVOT` of 50. This places year 00 at 2000, so a 29th of February in year 00 is in reach. Year 50 is in reach as a non-leap year from the 1900s, and the 99-to-00 wrap is reached without crossing a century rule. A behavioural date model in the bench follows every clock and compares all seven fields after each edge. The stimulus covers loaded times just before each rollover, a run of several thousand strobes through midnight and a leap day, sparse strobes, hold, and writes that arrive together with a strobe.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BCD_W = 8;
    localparam int NF    = 7;
    localparam int SEL_W = $clog2(NF + 1);

    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_MDAY = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_NONE = 3'd7
    } field_e;

    typedef logic [BCD_W-1:0] bcd_t;

    function automatic bcd_t bcd_inc(bcd_t v);
        bcd_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic int bcd_val(bcd_t v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic is_leap(bcd_t y, int pivot);
        int v;
        v = bcd_val(y);
        return ((v % 4) == 0) && !((v == 0) && (pivot <= 0));
    endfunction

    function automatic bcd_t month_len(bcd_t m, logic leap);
        bcd_t r;
        case (m)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic bcd_t field_lo(int i);
        if (i == int'(F_WDAY) || i == int'(F_MDAY) || i == int'(F_MON)) return 8'h01;
        return 8'h00;
    endfunction

    function automatic bcd_t field_hi(int i);
        bcd_t r;
        case (i)
            int'(F_SEC), int'(F_MIN): r = 8'h59;
            int'(F_HOUR):             r = 8'h23;
            int'(F_WDAY):             r = 8'h07;
            int'(F_MON):              r = 8'h12;
            int'(F_YEAR):             r = 8'h99;
            default:                  r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic bcd_t field_rst(int i);
        if (i == int'(F_WDAY)) return 8'h07;
        return field_lo(i);
    endfunction

    // Field whose rollover advances field i (i >= 1).
    function automatic int carry_src(int i);
        int r;
        case (i)
            int'(F_WDAY), int'(F_MDAY): r = int'(F_HOUR);
            int'(F_MON):                r = int'(F_MDAY);
            int'(F_YEAR):               r = int'(F_MON);
            default:                    r = i - 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_field.sv
module cal_field
    import cal_pkg::*;
#(
    parameter bcd_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic wr,
    input  bcd_t lo,
    input  bcd_t hi,
    input  bcd_t wdata,
    output bcd_t q
);

    logic at_top;
    assign at_top = (q >= hi);

    always_ff @(posedge clk) begin
        if (rst)      q <= RST_VAL;
        else if (wr)  q <= wdata;
        else if (inc) q <= at_top ? lo : bcd_inc(q);
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == $past(wdata))); // R9

    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr && (q >= hi)) |=> (q == $past(lo))); // R11

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr) |=> $stable(q)); // R8

endmodule

// File: rtl/cal_limits.sv
module cal_limits
    import cal_pkg::*;
#(
    parameter int YEAR_PIVOT = 50
) (
    input  bcd_t mon,
    input  bcd_t year,
    output bcd_t mday_hi
);

    logic leap;

    always_comb begin
        leap    = is_leap(year, YEAR_PIVOT);
        mday_hi = month_len(mon, leap);
    end

endmodule

// File: rtl/cal_carry.sv
module cal_carry
    import cal_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv,
    input  logic [NF-1:0][BCD_W-1:0]   q_all,
    input  logic [NF-1:0][BCD_W-1:0]   hi_all,
    output logic [NF-1:0]              inc
);

    always_comb begin
        inc[0] = adv;
        for (int i = 1; i < NF; i++) begin
            inc[i] = inc[carry_src(i)] && (q_all[carry_src(i)] >= hi_all[carry_src(i)]);
        end
    end

    AST_WEEK_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc[F_WDAY] && (q_all[F_WDAY] >= hi_all[F_WDAY])) |=> (q_all[F_WDAY] == 8'h01)); // R4

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc[F_YEAR] && (q_all[F_YEAR] >= hi_all[F_YEAR])) |=> (q_all[F_YEAR] == 8'h00)); // R7

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int YEAR_PIVOT = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [BCD_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [BCD_W-1:0] rd_data
);

    logic [NF-1:0][BCD_W-1:0] q_all;
    logic [NF-1:0][BCD_W-1:0] hi_all;
    logic [NF-1:0]            inc;
    bcd_t                     mday_hi;
    logic                     adv;

    // A write in the same cycle swallows the strobe.
    assign adv = tick && !hold && !wr_en;

    cal_limits #(.YEAR_PIVOT(YEAR_PIVOT)) u_lim (
        .mon     (q_all[F_MON]),
        .year    (q_all[F_YEAR]),
        .mday_hi (mday_hi)
    );

    cal_carry u_carry (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .q_all  (q_all),
        .hi_all (hi_all),
        .inc    (inc)
    );

    for (genvar i = 0; i < NF; i++) begin : g_fld
        if (i == int'(F_MDAY)) begin : g_var
            assign hi_all[i] = mday_hi;
        end else begin : g_fix
            assign hi_all[i] = field_hi(i);
        end

        cal_field #(.RST_VAL(field_rst(i))) u_f (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[i]),
            .wr    (wr_en && (wr_sel == SEL_W'(i))),
            .lo    (field_lo(i)),
            .hi    (hi_all[i]),
            .wdata (wr_data),
            .q     (q_all[i])
        );
    end

    assign rd_data = (rd_sel >= SEL_W'(NF)) ? '0 : q_all[rd_sel];

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold && !wr_en) |=> $stable(q_all)); // R8

    AST_WRITE_BLOCKS_SEC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel != SEL_W'(F_SEC))) |=> $stable(q_all[F_SEC])); // R10

    AST_SEC_MOVES: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !wr_en) |=> (q_all[F_SEC] != $past(q_all[F_SEC]))); // R2

endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/100ps
module sim_bcd_calendar;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    bcd_calendar u0 (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string req    = "R1";
    int    m [7];   // sec, min, hour, wday, mday, month, year (binary)

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void model_reset();
        m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 7; m[4] = 1; m[5] = 1; m[6] = 0;
    endfunction

    function automatic void model_advance();
        bit c;
        int lim;
        c = (m[0] >= 59); m[0] = c ? 0 : m[0] + 1;
        if (!c) return;
        c = (m[1] >= 59); m[1] = c ? 0 : m[1] + 1;
        if (!c) return;
        c = (m[2] >= 23); m[2] = c ? 0 : m[2] + 1;
        if (!c) return;
        m[3] = (m[3] >= 7) ? 1 : m[3] + 1;
        lim = days_in(m[5], m[6]);
        c = (m[4] >= lim); m[4] = c ? 1 : m[4] + 1;
        if (!c) return;
        c = (m[5] >= 12); m[5] = c ? 1 : m[5] + 1;
        if (!c) return;
        m[6] = (m[6] >= 99) ? 0 : m[6] + 1;
    endfunction

    task automatic check(string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 7; k++) begin
            rd_sel = 3'(k);
            #0.5;
            check($sformatf("field%0d", k), rd_data, to_bcd(m[k]));
        end
    endtask

    task automatic check_zero_sel();
        rd_sel = 3'd7;
        #0.5;
        check("sel7", rd_data, 8'h00);
    endtask

    // Drive one cycle of inputs, update the model, compare after the edge.
    task automatic step(bit t, bit h, bit we, logic [2:0] s, logic [7:0] d);
        tick = t; hold = h; wr_en = we; wr_sel = s; wr_data = d;
        @(posedge clk);
        if (we) begin
            if (s < 3'd7) m[s] = from_bcd(d);
        end else if (t && !h) begin
            model_advance();
        end
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; hold = 1'b0;
        compare_all();
    endtask

    task automatic set_time(int yr, int mo, int dy, int wd, int hr, int mi, int se);
        step(0, 0, 1, 3'd6, to_bcd(yr));
        step(0, 0, 1, 3'd5, to_bcd(mo));
        step(0, 0, 1, 3'd4, to_bcd(dy));
        step(0, 0, 1, 3'd3, to_bcd(wd));
        step(0, 0, 1, 3'd2, to_bcd(hr));
        step(0, 0, 1, 3'd1, to_bcd(mi));
        step(0, 0, 1, 3'd0, to_bcd(se));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        req = "R1";
        compare_all();
        check_zero_sel();

        req = "R2";
        repeat (15) step(1, 0, 0, 3'd0, 8'h00);
        for (int i = 0; i < 60; i++) step((i % 3) == 0, 0, 0, 3'd0, 8'h00);

        req = "R3";
        set_time(24, 3, 10, 2, 23, 59, 58);
        repeat (3) step(1, 0, 0, 3'd0, 8'h00);

        req = "R4";
        set_time(24, 3, 16, 7, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);

        req = "R5";
        set_time(24, 4, 30, 3, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(24, 1, 30, 3, 23, 59, 59);
        repeat (2) begin
            step(1, 0, 0, 3'd0, 8'h00);
            set_time(m[6], m[5], m[4], m[3], 23, 59, 59);
        end
        set_time(24, 11, 30, 5, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);

        req = "R6";
        set_time(0, 2, 28, 2, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(0, 2, 29, 3, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(1, 2, 28, 4, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(50, 2, 28, 3, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(96, 2, 28, 4, 23, 30, 0);
        repeat (4000) step(1, 0, 0, 3'd0, 8'h00);

        req = "R7";
        set_time(24, 12, 31, 3, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        set_time(99, 12, 31, 6, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);

        req = "R8";
        set_time(37, 6, 15, 2, 12, 34, 56);
        repeat (5) step(1, 1, 0, 3'd0, 8'h00);
        step(1, 0, 0, 3'd0, 8'h00);

        req = "R9";
        step(0, 0, 1, 3'd7, 8'h55);
        check_zero_sel();
        step(0, 0, 1, 3'd2, 8'h07);
        step(0, 0, 1, 3'd4, 8'h19);

        req = "R10";
        set_time(40, 8, 31, 1, 23, 59, 59);
        step(1, 0, 1, 3'd1, 8'h20);
        step(1, 0, 1, 3'd0, 8'h05);
        step(1, 0, 0, 3'd0, 8'h00);

        req = "R11";
        set_time(30, 4, 31, 4, 23, 59, 59);
        step(1, 0, 0, 3'd0, 8'h00);
        step(0, 0, 1, 3'd0, 8'h75);
        step(1, 0, 0, 3'd0, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule